// File: doc/BRIEF.md
# Execute-Only Flash Window Guard

This block filters every access headed for an on-chip flash array against a single protected window whose contents may be executed but never read as data, written or erased. Each request presents a byte address, an access kind and, for erases, a page count. The address is converted to a 64-bit double-word index relative to the flash base. That index is compared with a start offset, which is inclusive, and an end offset, which is also inclusive, so the first address outside the window is base + (end+1)×8. Inside the window only CPU instruction fetches pass. Every other source is refused: CPU data reads, DMA, debug, programming and erase.

The decision is combinational in the request cycle. A refused request reads back zero data instead of the array word. A registered violation pulse follows one clock later. The two window offsets sit in a small register file with a sticky lock bit, so that boot code can seal the window before untrusted code runs. A window of fewer than two double-words is treated as switched off.

Top module: `xo_flash_guard`

## Requirements
- R1: After reset both offsets read as zero, the lock reads as clear, and the window is disabled, so every access is granted.
- R2: The double-word index of a request is (addr − FLASH_BASE) >> 3. The index equal to the start offset lies inside the window. Addresses below FLASH_BASE are never inside it.
- R3: The index equal to the end offset lies inside the window and the index end+1 lies outside it. For example, with start 0xC5F0 and end 0xE000, addresses base+0x62F80 through base+0x70007 are protected.
- R4: An instruction fetch (type code 0) is always granted, including inside the window.
- R5: Inside the window, all other type codes are denied: data read (1), DMA read (2), debug read (3), write (4), and the unused codes 6 and 7.
- R6: An erase (type 5) covers whole pages of PAGE_BYTES, starting at the page that contains addr and spanning req_pages_i+1 pages. If any double-word of that range falls in the window, the whole erase is denied.
- R7: When end ≤ start the window is disabled and no access is denied. A window with end = start+1, which is two double-words, is active.
- R8: rdata_o equals flash_rdata_i when the request is granted and is zero when it is denied.
- R9: error_o is high for exactly the one cycle after each denied request, and low otherwise.
- R10: Config register select codes are 0 = start offset, 1 = end offset and 2 = lock. Writing 1 in bit 0 of the lock register sets the lock, and only reset clears it. While the lock is set, offset writes are ignored. cfg_rdata_o returns the selected register, with the lock shown in bit 0.
- R11: An access whose index lies outside an active window is granted for every type code.
- R12: With req_valid_i low, both grant_o and deny_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Config register write strobe |
| cfg_sel_i | input | 2 | Config register select |
| cfg_wdata_i | input | OFS_W | Config write data |
| cfg_rdata_o | output | OFS_W | Selected config register contents |
| req_valid_i | input | 1 | Access request present |
| req_addr_i | input | ADDR_W | Byte address of the access |
| req_type_i | input | 3 | Access kind code |
| req_pages_i | input | PG_W | Erase page count minus one |
| flash_rdata_i | input | 64 | Data word from the flash array |
| grant_o | output | 1 | Access allowed |
| deny_o | output | 1 | Access refused |
| rdata_o | output | 64 | Read data returned to the requester |
| error_o | output | 1 | Violation pulse, one cycle after a refusal |

## Verification
A corrupted offset register or a wrong lock state does not appear at the ports on its own. It appears only when the config readback is selected, or when a request lands on or next to a window edge. The bench therefore probes the exact boundary indices start, end and end+1, and reads the registers back after each write attempt. A wrong grant or deny decision is visible in the same cycle as the request, through grant_o, deny_o and rdata_o. A lost or extra violation pulse is visible on error_o exactly one clock later.

// File: rtl/xo_guard_pkg.sv
package xo_guard_pkg;
  typedef enum logic [2:0] {
    ACC_FETCH = 3'd0,
    ACC_DATA  = 3'd1,
    ACC_DMA   = 3'd2,
    ACC_DBG   = 3'd3,
    ACC_WRITE = 3'd4,
    ACC_ERASE = 3'd5
  } acc_e;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_END   = 2'd1,
    SEL_LOCK  = 2'd2
  } sel_e;
endpackage

// File: rtl/xo_guard_regs.sv
module xo_guard_regs #(
  parameter int OFS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [OFS_W-1:0] wdata_i,
  output logic [OFS_W-1:0] rdata_o,
  output logic [OFS_W-1:0] start_o,
  output logic [OFS_W-1:0] end_o,
  output logic             lock_o
);
  import xo_guard_pkg::*;

  logic [OFS_W-1:0] start_q, end_q;
  logic             lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
      lock_q  <= 1'b0;
    end else if (we_i) begin
      unique case (sel_e'(sel_i))
        SEL_START: if (!lock_q) start_q <= wdata_i;
        SEL_END:   if (!lock_q) end_q   <= wdata_i;
        SEL_LOCK:  if (wdata_i[0]) lock_q <= 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (sel_e'(sel_i))
      SEL_START: rdata_o = start_q;
      SEL_END:   rdata_o = end_q;
      SEL_LOCK:  rdata_o = {{(OFS_W-1){1'b0}}, lock_q};
      default:   rdata_o = '0;
    endcase
  end

  assign start_o = start_q;
  assign end_o   = end_q;
  assign lock_o  = lock_q;

  assert_lock_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  assert_locked_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> ($stable(start_q) && $stable(end_q)));
endmodule

// File: rtl/xo_guard_span.sv
module xo_guard_span #(
  parameter int          ADDR_W     = 32,
  parameter int          PG_W       = 8,
  parameter int          PAGE_BYTES = 2048,
  parameter logic [31:0] FLASH_BASE = 32'h0800_0000
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [PG_W-1:0]        pages_i,
  input  logic                   is_erase_i,
  output logic                   in_flash_o,
  output logic [ADDR_W+PG_W-1:0] lo_dw_o,
  output logic [ADDR_W+PG_W-1:0] hi_dw_o
);
  localparam int SW         = ADDR_W + PG_W;
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
  localparam int PG_DW_SH   = PAGE_SHIFT - 3;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(FLASH_BASE);

  logic [ADDR_W-1:0] off;
  logic [SW-1:0]     dw, pg_first, pg_cnt;

  always_comb begin
    off      = addr_i - BASE;
    dw       = SW'(off >> 3);
    pg_first = SW'(off >> PAGE_SHIFT) << PG_DW_SH;
    pg_cnt   = SW'(pages_i) + SW'(1);
    in_flash_o = (addr_i >= BASE);
    if (is_erase_i) begin
      lo_dw_o = pg_first;
      hi_dw_o = pg_first + (pg_cnt << PG_DW_SH) - SW'(1);
    end else begin
      lo_dw_o = dw;
      hi_dw_o = dw;
    end
  end
endmodule

// File: rtl/xo_guard_match.sv
module xo_guard_match #(
  parameter int OFS_W = 16,
  parameter int SW    = 40
) (
  input  logic [OFS_W-1:0] start_i,
  input  logic [OFS_W-1:0] end_i,
  input  logic             in_flash_i,
  input  logic [SW-1:0]    lo_dw_i,
  input  logic [SW-1:0]    hi_dw_i,
  output logic             win_en_o,
  output logic             hit_o
);
  // window holds at least two double-words
  assign win_en_o = (end_i > start_i);
  assign hit_o = win_en_o && in_flash_i &&
                 (lo_dw_i <= SW'(end_i)) && (hi_dw_i >= SW'(start_i));
endmodule

// File: rtl/xo_flash_guard.sv
module xo_flash_guard #(
  parameter int          ADDR_W     = 32,
  parameter int          OFS_W      = 16,
  parameter int          PG_W       = 8,
  parameter int          PAGE_BYTES = 2048,
  parameter logic [31:0] FLASH_BASE = 32'h0800_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [OFS_W-1:0]  cfg_wdata_i,
  output logic [OFS_W-1:0]  cfg_rdata_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_type_i,
  input  logic [PG_W-1:0]   req_pages_i,
  input  logic [63:0]       flash_rdata_i,
  output logic              grant_o,
  output logic              deny_o,
  output logic [63:0]       rdata_o,
  output logic              error_o
);
  import xo_guard_pkg::*;

  localparam int SW = ADDR_W + PG_W;

  logic [OFS_W-1:0] start_w, end_w;
  logic             lock_w, in_flash, win_en, hit, is_erase, is_fetch, error_q;
  logic [SW-1:0]    lo_dw, hi_dw;

  xo_guard_regs #(.OFS_W(OFS_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .start_o (start_w),
    .end_o   (end_w),
    .lock_o  (lock_w)
  );

  assign is_erase = (acc_e'(req_type_i) == ACC_ERASE);
  assign is_fetch = (acc_e'(req_type_i) == ACC_FETCH);

  xo_guard_span #(
    .ADDR_W(ADDR_W), .PG_W(PG_W), .PAGE_BYTES(PAGE_BYTES), .FLASH_BASE(FLASH_BASE)
  ) u_span (
    .addr_i     (req_addr_i),
    .pages_i    (req_pages_i),
    .is_erase_i (is_erase),
    .in_flash_o (in_flash),
    .lo_dw_o    (lo_dw),
    .hi_dw_o    (hi_dw)
  );

  xo_guard_match #(.OFS_W(OFS_W), .SW(SW)) u_match (
    .start_i    (start_w),
    .end_i      (end_w),
    .in_flash_i (in_flash),
    .lo_dw_i    (lo_dw),
    .hi_dw_i    (hi_dw),
    .win_en_o   (win_en),
    .hit_o      (hit)
  );

  assign deny_o  = req_valid_i && hit && !is_fetch;
  assign grant_o = req_valid_i && !deny_o;
  assign rdata_o = deny_o ? 64'd0 : flash_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) error_q <= 1'b0;
    else         error_q <= deny_o;
  end
  assign error_o = error_q;

  assert_fetch_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && is_fetch) |-> grant_o);
  assert_exclusive_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $onehot({grant_o, deny_o}));
  assert_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(grant_o || deny_o));
  assert_deny_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_o |-> (rdata_o == 64'd0));
  assert_err_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_o |=> error_o);
  assert_err_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deny_o |=> !error_o);
  assert_disabled_open_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_en |-> !deny_o);
  assert_erase_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && is_erase) |-> (hi_dw >= lo_dw));
endmodule

// File: tb/xo_flash_guard_test.sv
module xo_flash_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE  = 32'h0800_0000;
  localparam logic [63:0] FDATA = 64'hDEAD_BEEF_0123_4567;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_type = '0;
  logic [7:0]  req_pages = '0;
  logic        grant, deny, error;
  logic [63:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xo_flash_guard uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_type_i(req_type),
    .req_pages_i(req_pages), .flash_rdata_i(FDATA),
    .grant_o(grant), .deny_o(deny), .rdata_o(rdata), .error_o(error)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input string tag, input logic [1:0] sel, input logic [15:0] exp);
    @(negedge clk);
    cfg_sel = sel;
    #1 chk(tag, 64'(cfg_rdata), 64'(exp));
  endtask

  // drive one request, check same-cycle decision and next-cycle pulse
  task automatic access(input string tag, input logic [31:0] a, input logic [2:0] t,
                        input logic [7:0] pg, input bit exp_deny);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_type = t; req_pages = pg;
    #1;
    chk({tag, " deny"},  64'(deny),  64'(exp_deny));
    chk({tag, " grant"}, 64'(grant), 64'(!exp_deny));
    chk({tag, " rdata R8"}, rdata, exp_deny ? 64'd0 : FDATA);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " error R9"}, 64'(error), 64'(exp_deny));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cfg_read("R1 start", 2'd0, 16'h0);
    cfg_read("R1 end",   2'd1, 16'h0);
    cfg_read("R1 lock",  2'd2, 16'h0);
    #1 chk("R12 idle grant", 64'(grant), 64'd0);
    chk("R12 idle deny", 64'(deny), 64'd0);
    chk("R1 no error", 64'(error), 64'd0);
    access("R1 data read open", BASE, 3'd1, 8'd0, 1'b0);
  endtask

  task automatic t_bounds;
    cfg_write(2'd0, 16'hC5F0);
    cfg_write(2'd1, 16'hE000);
    cfg_read("R10 start rb", 2'd0, 16'hC5F0);
    cfg_read("R10 end rb",   2'd1, 16'hE000);
    access("R2 start dw",      BASE + 32'h62F80, 3'd1, 8'd0, 1'b1);
    access("R2 below start",   BASE + 32'h62F7F, 3'd1, 8'd0, 1'b0);
    access("R3 end dw",        BASE + 32'h70004, 3'd1, 8'd0, 1'b1);
    access("R3 end last byte", BASE + 32'h70007, 3'd2, 8'd0, 1'b1);
    access("R3 end+1",         BASE + 32'h70008, 3'd1, 8'd0, 1'b0);
    access("R2 below base",    32'h0006_2F80,    3'd1, 8'd0, 1'b0);
  endtask

  task automatic t_types;
    access("R4 fetch inside", BASE + 32'h68000, 3'd0, 8'd0, 1'b0);
    access("R4 fetch start",  BASE + 32'h62F80, 3'd0, 8'd0, 1'b0);
    access("R5 dma",          BASE + 32'h68000, 3'd2, 8'd0, 1'b1);
    access("R5 debug",        BASE + 32'h68000, 3'd3, 8'd0, 1'b1);
    access("R5 write",        BASE + 32'h68000, 3'd4, 8'd0, 1'b1);
    access("R5 code6",        BASE + 32'h68000, 3'd6, 8'd0, 1'b1);
    access("R5 code7",        BASE + 32'h68000, 3'd7, 8'd0, 1'b1);
    access("R11 write out",   BASE + 32'h10000, 3'd4, 8'd0, 1'b0);
    access("R11 debug out",   BASE + 32'h70008, 3'd3, 8'd0, 1'b0);
    access("R11 code7 out",   BASE + 32'h00000, 3'd7, 8'd0, 1'b0);
  endtask

  task automatic t_erase;
    // page 0xC4 spans dw 0xC400..0xC4FF, below start 0xC5F0
    access("R6 erase below",      BASE + 32'h62000, 3'd5, 8'd0, 1'b0);
    access("R6 erase into start", BASE + 32'h62000, 3'd5, 8'd1, 1'b1);
    access("R6 erase mid addr",   BASE + 32'h62F80, 3'd5, 8'd0, 1'b1);
    access("R6 erase end page",   BASE + 32'h70000, 3'd5, 8'd0, 1'b1);
    access("R6 erase after",      BASE + 32'h70800, 3'd5, 8'd3, 1'b0);
    access("R6 erase spanning",   BASE + 32'h00000, 3'd5, 8'd255, 1'b1);
  endtask

  task automatic t_disabled;
    cfg_write(2'd0, 16'h0010);
    cfg_write(2'd1, 16'h0010);
    access("R7 equal offsets", BASE + 32'h80, 3'd1, 8'd0, 1'b0);
    cfg_write(2'd1, 16'h000F);
    access("R7 end<start",     BASE + 32'h80, 3'd4, 8'd0, 1'b0);
    cfg_write(2'd1, 16'h0011);
    access("R7 min window lo", BASE + 32'h80, 3'd1, 8'd0, 1'b1);
    access("R7 min window hi", BASE + 32'h88, 3'd1, 8'd0, 1'b1);
    access("R7 min window out", BASE + 32'h90, 3'd1, 8'd0, 1'b0);
    @(negedge clk);
    chk("R9 pulse single", 64'(error), 64'd0);
  endtask

  task automatic t_lock;
    cfg_write(2'd2, 16'h0000);
    cfg_read("R10 lock needs bit0", 2'd2, 16'h0);
    cfg_write(2'd2, 16'h0001);
    cfg_read("R10 lock set", 2'd2, 16'h1);
    cfg_write(2'd0, 16'h1234);
    cfg_write(2'd1, 16'h5678);
    cfg_read("R10 start frozen", 2'd0, 16'h0010);
    cfg_read("R10 end frozen",   2'd1, 16'h0011);
    cfg_write(2'd2, 16'h0000);
    cfg_read("R10 lock sticky", 2'd2, 16'h1);
    access("R10 window kept", BASE + 32'h80, 3'd3, 8'd0, 1'b1);
    cfg_read("R10 sel3 zero", 2'd3, 16'h0);
  endtask

  initial begin
    t_reset();
    t_bounds();
    t_types();
    t_erase();
    t_disabled();
    t_lock();
    t_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule